// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is a per-processor countdown timer with a small write port. Software programs a start value, a clock divider and a timer entry that holds a mask flag, a mode flag and an 8-bit interrupt vector. The counter steps down once per prescaled tick. When it expires it raises a one-cycle request that carries the programmed vector. The current count can be read back on every cycle.

Two modes are available. In one-shot mode the count runs down to zero, requests once and then rests at zero. In periodic mode the count reloads from the start value on the tick after it reaches zero, so each period covers the start value plus one ticks. Writing the start value restarts counting at once, including the prescaler phase. Writing the divider or the timer entry leaves the running count alone.

Top module: `intr_countdown_timer`

## Requirements
- R1: After reset the count is 0, no request is pending and the timer entry is masked. A start value written without touching the entry then counts down but raises no request.
- R2: A divider write keeps only data bits 3, 1 and 0. They form the code {bit3, bit1, bit0}, the shift is (code + 1) mod 8, and the count steps once every 2^shift clocks. Code 7 divides by 1, and data bit 2 has no effect.
- R3: A write with select 0 loads the start value. The count shows that value on the cycle after the write edge and the prescaler phase restarts, so the k-th step lands k·2^shift edges after the write edge.
- R4: One-shot mode (entry bit 17 clear): the count falls to 0 and one request is raised on the cycle after the edge where it reaches 0. The count then stays at 0 until the next start-value write.
- R5: Periodic mode (entry bit 17 set, start value N > 0): the tick at count 0 reloads N and raises the request, so requests come every (N + 1)·2^shift clocks.
- R6: Periodic mode with a start value of 0 never raises a request, and the count stays at 0.
- R7: When entry bit 16 (mask) is set, no request is raised but the count still runs.
- R8: A request is high for exactly one cycle, and while it is high the vector output equals entry bits [7:0] as they were at expiry.
- R9: Writes with select 1 (divider) or select 2 (entry) do not change the current count. A new divider takes effect from the next prescaler comparison.
- R10: A write with select 3 has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 start value, 1 divider, 2 timer entry, 3 none |
| wr_data | input | CNT_W | Write data |
| cur_count | output | CNT_W | Current count |
| expire_pulse | output | 1 | One-cycle expiry request |
| expire_vector | output | 8 | Vector delivered with the request |

## Verification
The cycle-level checks run on every cycle. They cover loading the count after a start-value write, the one-shot count resting at zero, silence while masked, the single-cycle request width, and that no step moves the count by more than one except on a load or a reload. Each request is also checked to coincide with a count of zero or the start value. Other properties need whole scenarios: the exact period for each divider code, the wraparound of code 7 to divide-by-1, and the prescaler phase reset on restart. The same holds for the periodic reload spacing, the zero start value in periodic mode, and a divider change taking effect mid-count. The bench covers these with directed runs and seeded random configurations compared against closed-form expected counts and request times.

// File: rtl/tmr_pkg.sv
// Shared constants and types of the countdown timer.
// Assumes an 8-bit vector and a 3-bit divider shift.
package tmr_pkg;
    localparam int VEC_W        = 8;
    localparam int SHIFT_W      = 3;
    localparam int PRE_W        = (1 << SHIFT_W) - 1;
    localparam int MASK_BIT     = 16;
    localparam int PERIODIC_BIT = 17;
    localparam int DIV_HI_BIT   = 3;

    typedef enum logic [1:0] {
        SEL_INIT  = 2'd0,
        SEL_DIV   = 2'd1,
        SEL_ENTRY = 2'd2,
        SEL_NONE  = 2'd3
    } tmr_sel_e;

    typedef struct packed {
        logic             periodic;
        logic             masked;
        logic [VEC_W-1:0] vector;
    } tmr_entry_t;
endpackage

// File: rtl/tmr_regs.sv
// Holds the start value, the divider code and the timer entry.
// Decodes the write select. A start-value write also produces a
// one-cycle load strobe for the counter and the prescaler.
// Assumes CNT_W is at least PERIODIC_BIT + 1.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [CNT_W-1:0]   wr_data,
    output logic [CNT_W-1:0]   init_q,
    output logic [SHIFT_W-1:0] div_code,
    output tmr_entry_t         entry_q,
    output logic               init_load
);
    tmr_sel_e sel;
    assign sel       = tmr_sel_e'(wr_sel);
    assign init_load = wr_en && (sel == SEL_INIT);

    // Register writes. The entry resets to masked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q   <= '0;
            div_code <= '0;
            entry_q  <= '{periodic: 1'b0, masked: 1'b1, vector: '0};
        end else if (wr_en) begin
            case (sel)
                SEL_INIT:  init_q   <= wr_data;
                SEL_DIV:   div_code <= {wr_data[DIV_HI_BIT], wr_data[1:0]};
                SEL_ENTRY: entry_q  <= '{periodic: wr_data[PERIODIC_BIT],
                                         masked:   wr_data[MASK_BIT],
                                         vector:   wr_data[VEC_W-1:0]};
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/tmr_prescale.sv
// Turns the divider code into a power-of-two tick rate.
// shift = (code + 1) mod 8, and a tick fires every 2^shift clocks.
// The phase counter clears on restart. It compares with >=, so a
// smaller divider chosen mid-phase ticks at the next edge.
module tmr_prescale
    import tmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [SHIFT_W-1:0] div_code,
    output logic               tick
);
    logic [SHIFT_W-1:0] shift;
    logic [PRE_W-1:0]   lim;
    logic [PRE_W-1:0]   pre_q;

    // The shift wraps, so code 7 becomes divide-by-1.
    assign shift = div_code + SHIFT_W'(1);
    assign lim   = {PRE_W{1'b1}} >> (SHIFT_W'(PRE_W) - shift);
    assign tick  = (pre_q >= lim);

    // Phase counter: clears on restart and after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end
endmodule

// File: rtl/tmr_count.sv
// Down-counter with one-shot or periodic reload and a registered
// expiry request. A load wins over a tick in the same cycle and
// suppresses expiry. The mask blocks only the request.
module tmr_count
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] init_q,
    input  tmr_entry_t       entry,
    output logic [CNT_W-1:0] count_q,
    output logic             fire_q,
    output logic [VEC_W-1:0] vec_q
);
    logic [CNT_W-1:0] count_d;
    logic             fire_d;

    // Next count and expiry decision.
    always_comb begin
        count_d = count_q;
        fire_d  = 1'b0;
        if (load) begin
            count_d = load_val;
        end else if (tick) begin
            if (count_q != '0) begin
                count_d = count_q - CNT_W'(1);
                fire_d  = !entry.periodic && (count_q == CNT_W'(1));
            end else if (entry.periodic) begin
                count_d = init_q;
                fire_d  = (init_q != '0);
            end
        end
        fire_d = fire_d && !entry.masked;
    end

    // State update; the vector is captured together with the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            fire_q  <= 1'b0;
            vec_q   <= '0;
        end else begin
            count_q <= count_d;
            fire_q  <= fire_d;
            if (fire_d) begin
                vec_q <= entry.vector;
            end
        end
    end
endmodule

// File: rtl/intr_countdown_timer.sv
// Top of the countdown timer: register block, prescaler and counter.
// The request output is a one-cycle pulse with its vector alongside.
module intr_countdown_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [CNT_W-1:0]    wr_data,
    output logic [CNT_W-1:0]    cur_count,
    output logic                expire_pulse,
    output logic [VEC_W-1:0]    expire_vector
);
    logic [CNT_W-1:0]   init_q;
    logic [SHIFT_W-1:0] div_code;
    tmr_entry_t         entry_q;
    logic               init_load;
    logic               tick;

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .init_q    (init_q),
        .div_code  (div_code),
        .entry_q   (entry_q),
        .init_load (init_load)
    );

    tmr_prescale u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (init_load),
        .div_code (div_code),
        .tick     (tick)
    );

    tmr_count #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (init_load),
        .load_val (wr_data),
        .init_q   (init_q),
        .entry    (entry_q),
        .count_q  (cur_count),
        .fire_q   (expire_pulse),
        .vec_q    (expire_vector)
    );
endmodule

// File: rtl/intr_countdown_timer_chk.sv
// Cycle-level properties of the countdown timer, bound into the top.
module intr_countdown_timer_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] cur_count,
    input logic             expire_pulse,
    input logic [CNT_W-1:0] init_q,
    input tmr_entry_t       entry_q
);
    logic wr_init;
    assign wr_init = wr_en && (wr_sel == 2'd0);

    AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_init |=> cur_count == $past(wr_data)); // R3

    AST_ONESHOT_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (!entry_q.periodic && cur_count == '0 && !wr_init) |=> cur_count == '0); // R4

    AST_FIRE_POINT: assert property (@(posedge clk) disable iff (!rst_n)
        expire_pulse |-> (cur_count == '0 || cur_count == init_q)); // R5

    AST_ZERO_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_q.periodic && init_q == '0) |=> !expire_pulse); // R6

    AST_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        entry_q.masked |=> !expire_pulse); // R7

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        expire_pulse |=> !expire_pulse); // R8

    AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_init && cur_count != '0) |=>
        (cur_count == $past(cur_count) || cur_count == $past(cur_count) - CNT_W'(1))); // R9
endmodule

bind intr_countdown_timer intr_countdown_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .cur_count    (cur_count),
    .expire_pulse (expire_pulse),
    .init_q       (init_q),
    .entry_q      (entry_q)
);

// File: tb/intr_countdown_timer_tb.sv
`timescale 1ns/1ps
module intr_countdown_timer_tb;
    localparam int CNT_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_sel = 2'd0;
    logic [CNT_W-1:0] wr_data = '0;
    logic [CNT_W-1:0] cur_count;
    logic             expire_pulse;
    logic [7:0]       expire_vector;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    intr_countdown_timer #(.CNT_W(CNT_W)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_sel        (wr_sel),
        .wr_data       (wr_data),
        .cur_count     (cur_count),
        .expire_pulse  (expire_pulse),
        .expire_vector (expire_vector)
    );

    // Clocks per step for a divider data value (R2)
    function automatic int div_period(logic [3:0] d);
        logic [2:0] code;
        logic [2:0] sh;
        code = {d[3], d[1:0]};
        sh   = code + 3'd1;
        return 1 << sh;
    endfunction

    // Expected count m edges after the start-value write edge
    function automatic longint exp_count(longint n, int p, int m, bit per);
        longint t;
        t = m / p;
        if (per) begin
            if (n == 0) return 0;
            return n - (t % (n + 1));
        end
        return (t >= n) ? 0 : n - t;
    endfunction

    // Expected request m edges after the start-value write edge
    function automatic bit exp_pulse(longint n, int p, int m, bit per, bit masked);
        if (masked || m == 0 || n == 0) return 1'b0;
        if (per) return (m % ((n + 1) * p)) == 0;
        return m == n * p;
    endfunction

    task automatic check(string req, string what, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] s, logic [CNT_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [CNT_W-1:0] entry_word(bit per, bit masked, logic [7:0] vec);
        return (CNT_W'(per) << 17) | (CNT_W'(masked) << 16) | CNT_W'(vec);
    endfunction

    task automatic cfg(logic [3:0] dv, bit per, bit masked, logic [7:0] vec, longint n);
        wr(2'd1, CNT_W'(dv));
        wr(2'd2, entry_word(per, masked, vec));
        wr(2'd0, CNT_W'(n));
    endtask

    task automatic run(string req, longint n, logic [3:0] dv, bit per, bit masked,
                       logic [7:0] vec, int m_max);
        int p;
        p = div_period(dv);
        check(req, "count at load", longint'(cur_count), n);
        for (int m = 1; m <= m_max; m++) begin
            @(negedge clk);
            check(req, "count", longint'(cur_count), exp_count(n, p, m, per));
            check(req, "pulse", longint'(expire_pulse), longint'(exp_pulse(n, p, m, per, masked)));
            if (expire_pulse) check(req, "vector", longint'(expire_vector), longint'(vec));
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, then a masked default entry counts silently
        check("R1", "reset count", longint'(cur_count), 0);
        check("R1", "reset pulse", longint'(expire_pulse), 0);
        wr(2'd0, 3);
        run("R1", 3, 4'b0000, 0, 1, 8'h00, 12);

        // R2: divider decode variants (code 7, ignored bit 2, high bit)
        cfg(4'b1011, 0, 1, 8'h01, 5);  run("R2", 5, 4'b1011, 0, 1, 8'h01, 8);
        cfg(4'b0100, 0, 1, 8'h01, 6);  run("R2", 6, 4'b0100, 0, 1, 8'h01, 14);
        cfg(4'b1000, 0, 0, 8'h02, 2);  run("R2", 2, 4'b1000, 0, 0, 8'h02, 80);
        cfg(4'b0010, 0, 0, 8'h03, 3);  run("R2", 3, 4'b0010, 0, 0, 8'h03, 30);

        // R4 and R8: one-shot expiry with vector, then rest at zero
        cfg(4'b1011, 0, 0, 8'h5A, 4);  run("R4", 4, 4'b1011, 0, 0, 8'h5A, 20);

        // R5: periodic reload every (N+1)*P clocks
        cfg(4'b0000, 1, 0, 8'hC3, 3);  run("R5", 3, 4'b0000, 1, 0, 8'hC3, 40);

        // R6: periodic with a zero start value stays silent
        cfg(4'b1011, 1, 0, 8'h11, 0);  run("R6", 0, 4'b1011, 1, 0, 8'h11, 50);

        // R7: masked periodic keeps counting without requests
        cfg(4'b1011, 1, 1, 8'h22, 2);  run("R7", 2, 4'b1011, 1, 1, 8'h22, 30);

        // R9 and R10: side writes leave the count alone
        cfg(4'b1010, 0, 0, 8'h33, 50);
        repeat (10) @(negedge clk);
        check("R9", "count before side writes", longint'(cur_count), 50);
        wr(2'd2, entry_word(1, 0, 8'h44));
        check("R9", "count after entry write", longint'(cur_count), 50);
        wr(2'd3, 7);
        check("R10", "count after select-3 write", longint'(cur_count), 50);
        wr(2'd1, 4'b0011);
        check("R9", "count after divider write", longint'(cur_count), 50);
        @(negedge clk);
        check("R9", "new divider first step", longint'(cur_count), 49);
        repeat (16) @(negedge clk);
        check("R9", "new divider second step", longint'(cur_count), 48);

        // R3: restart mid-run, including prescaler phase reset
        cfg(4'b1011, 0, 0, 8'h66, 10);
        repeat (4) @(negedge clk);
        wr(2'd0, 5);
        run("R3", 5, 4'b1011, 0, 0, 8'h66, 12);
        cfg(4'b0001, 0, 0, 8'h67, 9);
        repeat (6) @(negedge clk);
        wr(2'd0, 9);
        run("R3", 9, 4'b0001, 0, 0, 8'h67, 45);

        // Seeded random configurations
        void'($urandom(32'h5EED));
        for (int i = 0; i < 16; i++) begin
            logic [3:0] dv;
            longint     n;
            bit         per;
            bit         msk;
            logic [7:0] vec;
            int         p;
            dv  = 4'($urandom);
            n   = longint'($urandom_range(0, 12));
            per = 1'($urandom);
            msk = ($urandom_range(0, 3) == 0);
            vec = 8'($urandom);
            p   = div_period(dv);
            cfg(dv, per, msk, vec, n);
            run(per ? "R5" : "R4", n, dv, per, msk, vec, int'((n + 1) * p * 2 + 3));
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule